// File: doc/BRIEF.md
# Halt Context Save Sequencer

This block runs a fixed multi-cycle sequence when a processor core is asked to hand control to its console, either after powerup or after an error. It copies the running context out of the way and installs a known console-entry context. The old program counter goes to a save-PC register. The old status word, the mapping-enable bit, a corruption flag and a 6-bit halt code are packed into one 32-bit save-status word. The live stack pointer is stored into one of five stack slots, and the slot is chosen by the 3-bit current-mode field of the old status word.

After the save, the block writes the console status word in two steps, clears mapping enable, loads the console program counter with an instruction-buffer flush, and loads the stack pointer from the interrupt-stack slot. The register file itself sits outside the block. The block drives write strobes and write data for every register it touches. It also drives level signals that keep prefetch and instruction decode off while it runs, and it ends the sequence with a one-cycle done pulse.

Top module: `halt_ctx_seq`

## Requirements
- R1: While `rst` is high, and after it is released with no request, every write strobe, `wbuf_clr_o`, `busy_o` and `done_o` are 0.
- R2: Exactly one `save_pc_we_o` pulse occurs per sequence, and `save_pc_o` then carries the `cur_pc_i` value present when the request was taken.
- R3: Exactly one `save_psl_we_o` pulse occurs per sequence. `save_psl_o` carries old status bits 31:16 in bits 31:16 and old bits 7:0 in bits 7:0. Bit 15 holds `cur_map_en_i` and bits 13:8 hold the halt code latched with the request. Old status bits 15:8 are discarded.
- R4: The mode code is old status bits 26:24. When it is 0 to 4, exactly one bit of `slot_we_o` pulses once: bit 0 kernel, 1 executive, 2 supervisor, 3 user, 4 interrupt. The bit index equals the mode code, and `slot_data_o` then carries the old stack pointer.
- R5: Mode codes 5, 6 and 7 set save-status bit 14, and no bit of `slot_we_o` pulses. For codes 0 to 4, bit 14 is 0.
- R6: `psl_we_o` pulses exactly twice. The first write carries 0x001F0000 and the second carries 0x041F0000, which is the first value with bit 26 set. The second write comes two cycles after the first.
- R7: `pc_we_o` pulses exactly once with `pc_o` = 0x20040000, and `ib_flush_o` is high in that same cycle.
- R8: `map_clr_o` (write mapping enable to 0) pulses exactly once, and `pf_disable_o` is high in that cycle.
- R9: `sp_we_o` pulses exactly once. `sp_o` carries the interrupt-slot value read through `isp_i` after the slot write of R4, and `mm_rearm_o` is high in the same cycle.
- R10: `wbuf_clr_o` pulses exactly once per sequence, in a cycle before the save-PC write.
- R11: `decode_hold_o` is high in every cycle from the first cycle after the request is taken up to and including the done cycle. It is therefore high for at least two cycles after each status-word write.
- R12: `done_o` is a single-cycle pulse that comes in the cycle right after the `sp_we_o` cycle.
- R13: A request is taken only when the block is idle. A request raised while `busy_o` is high does not restart the sequence and does not change the latched halt code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | Console halt request |
| halt_code_i | input | 6 | Halt reason code, latched with the request |
| cur_pc_i | input | 32 | Live program counter |
| cur_psl_i | input | 32 | Live status word; bits 26:24 are the mode code |
| cur_sp_i | input | 32 | Live stack pointer |
| cur_map_en_i | input | 1 | Live mapping-enable bit |
| isp_i | input | 32 | Current interrupt-stack slot value from the register file |
| busy_o | output | 1 | Sequence in progress |
| pf_disable_o | output | 1 | Prefetch disable, held during the sequence |
| decode_hold_o | output | 1 | Instruction decode hold, held during the sequence |
| wbuf_clr_o | output | 1 | Write-buffer clear pulse |
| save_pc_we_o | output | 1 | Save-PC register write strobe |
| save_pc_o | output | 32 | Save-PC write data |
| save_psl_we_o | output | 1 | Save-status register write strobe |
| save_psl_o | output | 32 | Packed save-status write data |
| slot_we_o | output | NSLOT | One-hot stack slot write strobes |
| slot_data_o | output | 32 | Stack slot write data |
| psl_we_o | output | 1 | Status word write strobe |
| psl_o | output | 32 | Status word write data |
| map_clr_o | output | 1 | Mapping-enable clear strobe |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_o | output | 32 | Program counter write data |
| ib_flush_o | output | 1 | Instruction buffer flush |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_o | output | 32 | Stack pointer write data |
| mm_rearm_o | output | 1 | Memory management microtrap re-arm |
| done_o | output | 1 | Sequence complete pulse |

## Verification
The bench sweeps all eight mode codes with mapping enable both 0 and 1 and halt codes that include 0 and 63. A decoder that got the slot mapping wrong would strobe the wrong slot or write one for codes 5 to 7, and a packer that got the fields wrong would leak old status bits 15:8 or misplace the halt code. Mode 4 is the hardest case for the final stack pointer, because the value loaded must be the one just stored, not the stale slot contents. A request raised in the middle of a sequence checks that a design that re-arms would run twice or overwrite the latched code. The bench also checks the two-step status write, the cycle gap between the two writes, and the position of the done pulse.

// File: rtl/halt_ctx_pkg.sv
package halt_ctx_pkg;

  localparam int XLEN      = 32;
  localparam int CODE_W    = 6;
  localparam int MODE_W    = 3;
  localparam int MODE_LSB  = 24;
  localparam int IS_BIT    = 26;
  localparam int MAP_BIT   = 15;
  localparam int BAD_BIT   = 14;
  localparam int CODE_LSB  = 8;

  localparam logic [XLEN-1:0] CONSOLE_PSL_BASE = 32'h001F_0000;
  localparam logic [XLEN-1:0] CONSOLE_PC       = 32'h2004_0000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GRAB_SP,
    ST_GRAB_PC,
    ST_GRAB_PSL,
    ST_SAVE,
    ST_PSL_BASE,
    ST_MAP_OFF,
    ST_PSL_IS,
    ST_LOAD_PC,
    ST_FETCH_ISP,
    ST_LOAD_SP,
    ST_FINISH
  } seq_state_e;

  function automatic logic [XLEN-1:0] pack_save_word(
    input logic [XLEN-1:0]   psl,
    input logic              map_en,
    input logic              bad_mode,
    input logic [CODE_W-1:0] code
  );
    logic [XLEN-1:0] w;
    w = psl;
    w[MAP_BIT:CODE_LSB]                 = '0;
    w[MAP_BIT]                          = map_en;
    w[BAD_BIT]                          = bad_mode;
    w[CODE_LSB +: CODE_W]               = code;
    return w;
  endfunction

endpackage

// File: rtl/halt_seq_ctrl.sv
module halt_seq_ctrl
  import halt_ctx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  output seq_state_e state_q,
  output logic       accept_o
);

  seq_state_e state_d;

  assign accept_o = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_i) state_d = ST_GRAB_SP;
      ST_GRAB_SP:   state_d = ST_GRAB_PC;
      ST_GRAB_PC:   state_d = ST_GRAB_PSL;
      ST_GRAB_PSL:  state_d = ST_SAVE;
      ST_SAVE:      state_d = ST_PSL_BASE;
      ST_PSL_BASE:  state_d = ST_MAP_OFF;
      ST_MAP_OFF:   state_d = ST_PSL_IS;
      ST_PSL_IS:    state_d = ST_LOAD_PC;
      ST_LOAD_PC:   state_d = ST_FETCH_ISP;
      ST_FETCH_ISP: state_d = ST_LOAD_SP;
      ST_LOAD_SP:   state_d = ST_FINISH;
      ST_FINISH:    state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/halt_ctx_capture.sv
module halt_ctx_capture
  import halt_ctx_pkg::*;
#(
  parameter int NSLOT = 5
)(
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state_q,
  input  logic              accept_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   psl_i,
  input  logic [XLEN-1:0]   sp_i,
  input  logic              map_en_i,
  input  logic [XLEN-1:0]   isp_i,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   sp_q,
  output logic [XLEN-1:0]   save_word_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              bad_q,
  output logic [XLEN-1:0]   isp_q,
  output logic [XLEN-1:0]   psl_new_q
);

  logic [CODE_W-1:0] code_q;
  logic [MODE_W-1:0] mode_now;
  logic              bad_now;

  assign mode_now = psl_i[MODE_LSB +: MODE_W];
  assign bad_now  = (int'(mode_now) >= NSLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q      <= '0;
      pc_q        <= '0;
      sp_q        <= '0;
      save_word_q <= '0;
      mode_q      <= '0;
      bad_q       <= 1'b0;
      isp_q       <= '0;
      psl_new_q   <= '0;
    end else begin
      if (accept_i)                  code_q <= code_i;
      if (state_q == ST_GRAB_SP)     sp_q   <= sp_i;
      if (state_q == ST_GRAB_PC)     pc_q   <= pc_i;
      if (state_q == ST_GRAB_PSL) begin
        mode_q      <= mode_now;
        bad_q       <= bad_now;
        save_word_q <= pack_save_word(psl_i, map_en_i, bad_now, code_q);
      end
      if (state_q == ST_SAVE)        psl_new_q <= CONSOLE_PSL_BASE;
      if (state_q == ST_MAP_OFF)     psl_new_q[IS_BIT] <= 1'b1;
      if (state_q == ST_FETCH_ISP)   isp_q  <= isp_i;
    end
  end

endmodule

// File: rtl/halt_slot_router.sv
module halt_slot_router
  import halt_ctx_pkg::*;
#(
  parameter int NSLOT = 5
)(
  input  logic              save_en_i,
  input  logic              bad_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [NSLOT-1:0]  slot_we_o
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_we_o[i] = save_en_i && !bad_i && (mode_i == MODE_W'(i));
  end

endmodule

// File: rtl/halt_ctx_seq.sv
module halt_ctx_seq
  import halt_ctx_pkg::*;
#(
  parameter int NSLOT = 5
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req_i,
  input  logic [5:0]        halt_code_i,
  input  logic [31:0]       cur_pc_i,
  input  logic [31:0]       cur_psl_i,
  input  logic [31:0]       cur_sp_i,
  input  logic              cur_map_en_i,
  input  logic [31:0]       isp_i,
  output logic              busy_o,
  output logic              pf_disable_o,
  output logic              decode_hold_o,
  output logic              wbuf_clr_o,
  output logic              save_pc_we_o,
  output logic [31:0]       save_pc_o,
  output logic              save_psl_we_o,
  output logic [31:0]       save_psl_o,
  output logic [NSLOT-1:0]  slot_we_o,
  output logic [31:0]       slot_data_o,
  output logic              psl_we_o,
  output logic [31:0]       psl_o,
  output logic              map_clr_o,
  output logic              pc_we_o,
  output logic [31:0]       pc_o,
  output logic              ib_flush_o,
  output logic              sp_we_o,
  output logic [31:0]       sp_o,
  output logic              mm_rearm_o,
  output logic              done_o
);

  localparam int MAX_MODES = 1 << MODE_W;

  seq_state_e        state_q;
  logic              accept;
  logic [XLEN-1:0]   pc_q, sp_q, save_word_q, isp_q, psl_new_q;
  logic [MODE_W-1:0] mode_q;
  logic              bad_q;
  logic              in_save;

  halt_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_i    (halt_req_i),
    .state_q  (state_q),
    .accept_o (accept)
  );

  halt_ctx_capture #(.NSLOT(NSLOT)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .accept_i    (accept),
    .code_i      (halt_code_i),
    .pc_i        (cur_pc_i),
    .psl_i       (cur_psl_i),
    .sp_i        (cur_sp_i),
    .map_en_i    (cur_map_en_i),
    .isp_i       (isp_i),
    .pc_q        (pc_q),
    .sp_q        (sp_q),
    .save_word_q (save_word_q),
    .mode_q      (mode_q),
    .bad_q       (bad_q),
    .isp_q       (isp_q),
    .psl_new_q   (psl_new_q)
  );

  assign in_save = (state_q == ST_SAVE);

  halt_slot_router #(.NSLOT(NSLOT)) u_route (
    .save_en_i (in_save),
    .bad_i     (bad_q),
    .mode_i    (mode_q),
    .slot_we_o (slot_we_o)
  );

  // All strobes are decodes of the single state register.
  assign busy_o        = (state_q != ST_IDLE);
  assign pf_disable_o  = busy_o;
  assign decode_hold_o = busy_o;
  assign wbuf_clr_o    = (state_q == ST_GRAB_PC);
  assign save_pc_we_o  = in_save;
  assign save_psl_we_o = in_save;
  assign save_pc_o     = pc_q;
  assign save_psl_o    = save_word_q;
  assign slot_data_o   = sp_q;
  assign psl_we_o      = (state_q == ST_PSL_BASE) || (state_q == ST_PSL_IS);
  assign psl_o         = psl_new_q;
  assign map_clr_o     = (state_q == ST_MAP_OFF);
  assign pc_we_o       = (state_q == ST_LOAD_PC);
  assign ib_flush_o    = pc_we_o;
  assign pc_o          = CONSOLE_PC;
  assign sp_we_o       = (state_q == ST_LOAD_SP);
  assign mm_rearm_o    = sp_we_o;
  assign sp_o          = isp_q;
  assign done_o        = (state_q == ST_FINISH);

  initial begin
    if (NSLOT < 1 || NSLOT > MAX_MODES) $error("NSLOT out of range");
  end

endmodule

// File: rtl/halt_ctx_seq_chk.sv
module halt_ctx_seq_chk #(
  parameter int NSLOT = 5
)(
  input logic             clk,
  input logic             rst,
  input logic             busy_o,
  input logic             pf_disable_o,
  input logic             decode_hold_o,
  input logic             save_psl_we_o,
  input logic [31:0]      save_psl_o,
  input logic [NSLOT-1:0] slot_we_o,
  input logic             psl_we_o,
  input logic [31:0]      psl_o,
  input logic             map_clr_o,
  input logic             sp_we_o,
  input logic             done_o
);

  p_slot_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_we_o));

  p_bad_mode_noslot_r5: assert property (@(posedge clk) disable iff (rst)
    (save_psl_we_o && save_psl_o[14]) |-> (slot_we_o == '0));

  p_psl_gap_r6: assert property (@(posedge clk) disable iff (rst)
    psl_we_o |=> !psl_we_o);

  p_psl_order_r6: assert property (@(posedge clk) disable iff (rst)
    (psl_we_o && psl_o[26]) |-> ($past(psl_we_o, 2) && !$past(psl_o[26], 2)));

  p_map_pf_r8: assert property (@(posedge clk) disable iff (rst)
    map_clr_o |-> pf_disable_o);

  p_hold_after_psl_r11: assert property (@(posedge clk) disable iff (rst)
    psl_we_o |=> decode_hold_o);

  p_done_after_sp_r12: assert property (@(posedge clk) disable iff (rst)
    sp_we_o |=> done_o);

  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_busy_holds_r13: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);

endmodule

bind halt_ctx_seq halt_ctx_seq_chk #(.NSLOT(NSLOT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy_o        (busy_o),
  .pf_disable_o  (pf_disable_o),
  .decode_hold_o (decode_hold_o),
  .save_psl_we_o (save_psl_we_o),
  .save_psl_o    (save_psl_o),
  .slot_we_o     (slot_we_o),
  .psl_we_o      (psl_we_o),
  .psl_o         (psl_o),
  .map_clr_o     (map_clr_o),
  .sp_we_o       (sp_we_o),
  .done_o        (done_o)
);

// File: tb/halt_ctx_seq_test.sv
`timescale 1ns/1ps
module halt_ctx_seq_test;

  localparam int NSLOT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 1'b0;
  logic [5:0]  code_in = '0;
  logic [31:0] pc_in = '0, psl_in = '0, sp_in = '0;
  logic        map_in = 1'b0;
  logic [31:0] isp;
  logic busy, pfd, hold, wbuf, spc_we, spsl_we, psl_we, mapc, pc_we, flush, sp_we, rearm, done;
  logic [31:0] spc, spsl, sdata, psl_w, pc_w, sp_w;
  logic [NSLOT-1:0] slot_we;

  logic [31:0] slot_m [NSLOT];
  assign isp = slot_m[4];

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  halt_ctx_seq #(.NSLOT(NSLOT)) uut (
    .clk(clk), .rst(rst), .halt_req_i(halt_req), .halt_code_i(code_in),
    .cur_pc_i(pc_in), .cur_psl_i(psl_in), .cur_sp_i(sp_in), .cur_map_en_i(map_in),
    .isp_i(isp), .busy_o(busy), .pf_disable_o(pfd), .decode_hold_o(hold),
    .wbuf_clr_o(wbuf), .save_pc_we_o(spc_we), .save_pc_o(spc),
    .save_psl_we_o(spsl_we), .save_psl_o(spsl), .slot_we_o(slot_we),
    .slot_data_o(sdata), .psl_we_o(psl_we), .psl_o(psl_w), .map_clr_o(mapc),
    .pc_we_o(pc_we), .pc_o(pc_w), .ib_flush_o(flush), .sp_we_o(sp_we),
    .sp_o(sp_w), .mm_rearm_o(rearm), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [2:0] mode, input logic map, input logic [5:0] code,
                          input logic [31:0] seed, input bit again);
    logic [31:0] exp_save, exp_sp, exp_slot [NSLOT];
    logic [31:0] got_spc, got_spsl, got_sp, psl1, psl2;
    int n_spc, n_spsl, n_psl, n_map, n_pc, n_sp, n_done, n_wbuf, n_slotw;
    int c_wbuf, c_spc, c_psl1, c_psl2, c_sp, c_done;
    bit hold_ok, pf_ok, flush_ok, rearm_ok, slot_ok, pc_ok, idle_ok;
    bit bad;
    n_spc = 0; n_spsl = 0; n_psl = 0; n_map = 0; n_pc = 0; n_sp = 0; n_done = 0;
    n_wbuf = 0; n_slotw = 0; c_wbuf = 0; c_spc = 0; c_psl1 = 0; c_psl2 = 0; c_sp = 0; c_done = 0;
    hold_ok = 1; pf_ok = 1; flush_ok = 1; rearm_ok = 1; slot_ok = 1; pc_ok = 1; idle_ok = 1;
    got_spc = '0; got_spsl = '0; got_sp = '0; psl1 = '0; psl2 = '0;
    for (int i = 0; i < NSLOT; i++) slot_m[i] = 32'h1000_0000 + (i << 8) + seed;

    pc_in  = 32'h8000_1234 ^ (seed * 32'h0101_0101);
    sp_in  = 32'h7FFF_0000 + seed * 4;
    map_in = map;
    psl_in = {5'b10101 ^ seed[4:0], mode, 8'h5A ^ seed[7:0], 8'hA5, 8'h3C ^ seed[15:8]};
    bad = (mode > 3'd4);
    exp_save = {psl_in[31:16], map, bad, code, psl_in[7:0]};
    for (int i = 0; i < NSLOT; i++) exp_slot[i] = slot_m[i];
    if (!bad) exp_slot[mode] = sp_in;
    exp_sp = exp_slot[4];

    @(negedge clk);
    halt_req = 1'b1; code_in = code;
    @(negedge clk);
    halt_req = 1'b0;
    for (int k = 1; k < 40; k++) begin
      if (!hold) hold_ok = 0;
      if (wbuf)   begin n_wbuf++; c_wbuf = k; end
      if (spc_we) begin n_spc++; c_spc = k; got_spc = spc; end
      if (spsl_we) begin n_spsl++; got_spsl = spsl; end
      if (slot_we != '0) begin
        for (int i = 0; i < NSLOT; i++) if (slot_we[i]) begin n_slotw++; slot_m[i] = sdata; end
      end
      if (psl_we) begin
        n_psl++;
        if (n_psl == 1) begin psl1 = psl_w; c_psl1 = k; end
        else begin psl2 = psl_w; c_psl2 = k; end
      end
      if (mapc) begin n_map++; if (!pfd) pf_ok = 0; end
      if (pc_we) begin n_pc++; if (!flush) flush_ok = 0; if (pc_w != 32'h2004_0000) pc_ok = 0; end
      if (sp_we) begin n_sp++; c_sp = k; got_sp = sp_w; if (!rearm) rearm_ok = 0; end
      if (done) begin n_done++; c_done = k; end
      if (again && k == 3) begin halt_req = 1'b1; code_in = ~code; end
      else halt_req = 1'b0;
      @(negedge clk);
      if (n_done != 0) break;
    end
    halt_req = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (busy || done || sp_we || spc_we) idle_ok = 0;
      @(negedge clk);
    end
    for (int i = 0; i < NSLOT; i++) if (slot_m[i] != exp_slot[i]) slot_ok = 0;

    check(n_spc == 1 && got_spc == pc_in, "R2 save pc", got_spc, pc_in);
    check(n_spsl == 1 && got_spsl == exp_save, "R3 save status packing", got_spsl, exp_save);
    if (!bad) check(slot_ok && n_slotw == 1, "R4 slot routing", n_slotw, 1);
    else check(slot_ok && n_slotw == 0 && got_spsl[14], "R5 bad mode no slot write", n_slotw, 0);
    check(n_psl == 2 && psl1 == 32'h001F_0000 && psl2 == 32'h041F_0000 && c_psl2 == c_psl1 + 2,
          "R6 status writes", psl2, 32'h041F_0000);
    check(n_pc == 1 && flush_ok && pc_ok, "R7 pc load with flush", n_pc, 1);
    check(n_map == 1 && pf_ok, "R8 map clear under prefetch disable", n_map, 1);
    check(n_sp == 1 && rearm_ok && got_sp == exp_sp, "R9 sp from interrupt slot", got_sp, exp_sp);
    check(n_wbuf == 1 && c_wbuf < c_spc, "R10 write buffer clear", n_wbuf, 1);
    check(hold_ok, "R11 decode hold through done", hold_ok, 1);
    check(n_done == 1 && c_done == c_sp + 1, "R12 done after sp load", c_done, c_sp + 1);
    if (again)
      check(idle_ok && got_spsl[13:8] == code, "R13 request during run ignored", got_spsl[13:8], code);
  endtask

  initial begin
    for (int i = 0; i < NSLOT; i++) slot_m[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !wbuf && slot_we == '0 && !psl_we && !sp_we, "R1 reset state", busy, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !done && !spc_we && !spsl_we && !pc_we && !mapc, "R1 idle after reset", busy, 0);
    for (int m = 0; m < 8; m++) begin
      for (int mp = 0; mp < 2; mp++) begin
        run_case(3'(m), mp[0], (m == 0) ? 6'd0 : (m == 7) ? 6'd63 : 6'(m * 9 + mp),
                 32'(m * 2 + mp + 1), 1'b0);
      end
    end
    run_case(3'd4, 1'b1, 6'h2A, 32'd40, 1'b1);
    run_case(3'd6, 1'b0, 6'h15, 32'd41, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule